// File: doc/BRIEF.md
# Variable-Width Bit Packer

This block gathers narrow samples from a 16-line parallel port and packs them into a dense stream of bytes. An external sampling clock, asynchronous to the system clock, marks each sample. On every rising edge of that clock the block takes N bits, where N is chosen at run time from 1 to 8. The bits are appended to a running bit stream, least significant first, with no padding. A sample that does not fit in the current byte continues into the next one.

Two options change the bit mapping. The first reverses the order of all sixteen input lines before the low N bits are taken. The second mirrors the bit order of every byte as it leaves the block. Bytes leave through a valid/ready handshake. When the consumer stalls for long enough that a new sample cannot be stored, the sample is dropped and a sticky overflow flag is raised. Changing the width, or pulsing the clear input, throws away any bits that do not yet form a byte.

Top module: `bitpack_top`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0.
- R2: `width_m1` holds N−1, so 0..7 select 1..8 bits. Only mapped bits 0..N−1 of each sample enter the stream. All other lines have no effect on the output.
- R3: Samples are packed LSB first. Bit 0 of the first sample after a flush is bit 0 of the first byte. Later samples follow with no gaps and cross byte boundaries where needed. For example, with N=4, the samples 0x3 then 0xA give the byte 0xA3.
- R4: When `rev_lines` is 0, line k is mapped bit k. When it is 1, line 15−k is mapped bit k, so line 15 becomes bit 0.
- R5: When `rev_bits` is 1, bit j of each emitted byte is stream bit 7−j. When it is 0, bit j is stream bit j.
- R6: Each rising edge of `line_clk` yields exactly one sample, however long the clock stays high.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. A byte is transferred on a clock where both are 1.
- R8: A sample is dropped when the held bits plus N would exceed the 16-bit accumulator. A drop sets `overflow`, which stays at 1 until `clear`. The bytes already held are delivered in order.
- R9: A change of `width_m1` discards every bit held in the accumulator. Packing restarts at bit 0 of a fresh byte.
- R10: A one-cycle `clear` empties the accumulator, withdraws any pending output byte and resets `overflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of all held data and of the overflow flag |
| width_m1 | input | 3 | Sample width minus one |
| rev_lines | input | 1 | Reverse the order of the 16 input lines |
| rev_bits | input | 1 | Mirror the bit order within each output byte |
| line_clk | input | 1 | Asynchronous sampling clock |
| lines | input | 16 | Parallel sample lines |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the byte |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
A wrong fill count or a wrong shift in the accumulator shows up as a misplaced or doubled bit. It appears at the ports within the byte that straddles the faulty sample, so it is visible about five clocks after that sample's edge. Widths 1 to 8 are each run against a bit-serial model, so every straddling offset is exercised. A wrong fullness limit shows as an early or missing overflow flag and as a wrong count of delivered bytes once a stall is released. Flush faults leave stale low bits in the first byte after a width change or a clear.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned LINES_DEF = 16;
  localparam int unsigned BYTE_DEF  = 8;
  localparam int unsigned ACC_DEF   = 16;

  // width code (N-1) to bit count N
  function automatic logic [3:0] width_count(input logic [2:0] code);
    return {1'b0, code} + 4'd1;
  endfunction

  // true when a sample of n bits fits behind `held` bits in an acc of size cap
  function automatic logic sample_fits(input logic [5:0] held, input logic [5:0] n,
                                       input logic [5:0] cap);
    return (held + n) <= cap;
  endfunction
endpackage

// File: rtl/bp_edge_sync.sv
module bp_edge_sync #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_clk,
  input  logic [LINES-1:0] lines,
  output logic             stb,
  output logic [LINES-1:0] stb_data
);
  logic [STAGES:0]  ck_q;
  logic [LINES-1:0] d_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      for (int i = 0; i < STAGES; i++) d_q[i] <= '0;
    end else begin
      ck_q   <= {ck_q[STAGES-1:0], line_clk};
      d_q[0] <= lines;
      for (int i = 1; i < STAGES; i++) d_q[i] <= d_q[i-1];
    end
  end

  assign stb      = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign stb_data = d_q[STAGES-1];

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/bp_line_map.sv
module bp_line_map #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WSEL_W = $clog2(BYTE_W)
) (
  input  logic [LINES-1:0]  raw,
  input  logic              rev_lines,
  input  logic [WSEL_W-1:0] width_m1,
  output logic [BYTE_W-1:0] bits
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic pick;
    assign pick    = rev_lines ? raw[LINES-1-i] : raw[i];
    assign bits[i] = pick & (width_m1 >= WSEL_W'(i));
  end
endmodule

// File: rtl/bp_accum.sv
module bp_accum #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ACC_W  = 16,
  localparam int unsigned CW    = $clog2(ACC_W + 1),
  localparam int unsigned NB_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              clr_flag,
  input  logic              stb,
  input  logic [BYTE_W-1:0] bits,
  input  logic [NB_W-1:0]   nbits,
  input  logic              slot_free,
  output logic              move,
  output logic [BYTE_W-1:0] move_byte,
  output logic              drop,
  output logic              ovf
);
  logic [ACC_W-1:0] acc_q, acc_a, acc_n;
  logic [CW-1:0]    cnt_q, cnt_a, cnt_n;
  logic             fits;

  always_comb begin
    move  = (cnt_q >= CW'(BYTE_W)) && slot_free && !flush;
    acc_a = move ? (acc_q >> BYTE_W) : acc_q;
    cnt_a = move ? (cnt_q - CW'(BYTE_W)) : cnt_q;
    fits  = bp_pkg::sample_fits(6'(cnt_a), 6'(nbits), 6'(ACC_W));
    drop  = stb && !fits && !flush;
    acc_n = acc_a;
    cnt_n = cnt_a;
    if (stb && fits) begin
      acc_n = acc_a | (ACC_W'(bits) << cnt_a);
      cnt_n = cnt_a + CW'(nbits);
    end
  end

  assign move_byte = acc_q[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (flush) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_n;
        cnt_q <= cnt_n;
      end
      if (clr_flag)  ovf <= 1'b0;
      else if (drop) ovf <= 1'b1;
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(ACC_W));
  assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !clr_flag |=> ovf);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_flag |=> ovf);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/bp_out_stage.sv
module bp_out_stage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              rev_bits,
  input  logic              ready,
  output logic              slot_free,
  output logic              valid,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] mirrored;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mir
    assign mirrored[i] = byte_in[BYTE_W-1-i];
  end

  assign slot_free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= rev_bits ? mirrored : byte_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !clear |=> valid && $stable(data));
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !valid);
endmodule

// File: rtl/bitpack_top.sv
module bitpack_top #(
  parameter int unsigned LINES       = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ACC_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WSEL_W     = $clog2(BYTE_W),
  localparam int unsigned NB_W       = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [WSEL_W-1:0] width_m1,
  input  logic              rev_lines,
  input  logic              rev_bits,
  input  logic              line_clk,
  input  logic [LINES-1:0]  lines,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              overflow
);
  logic              stb;
  logic [LINES-1:0]  stb_data;
  logic [BYTE_W-1:0] sample_bits;
  logic [WSEL_W-1:0] wsel_q;
  logic              width_chg, flush;
  logic              slot_free, move, drop;
  logic [BYTE_W-1:0] move_byte;
  logic [NB_W-1:0]   nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsel_q <= '0;
    else        wsel_q <= width_m1;
  end

  assign width_chg = (wsel_q != width_m1);
  assign flush     = clear | width_chg;
  assign nbits     = NB_W'(width_m1) + NB_W'(1);

  bp_edge_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .lines(lines),
    .stb(stb), .stb_data(stb_data));

  bp_line_map #(.LINES(LINES), .BYTE_W(BYTE_W)) u_map (
    .raw(stb_data), .rev_lines(rev_lines), .width_m1(width_m1), .bits(sample_bits));

  bp_accum #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .flush(flush), .clr_flag(clear),
    .stb(stb), .bits(sample_bits), .nbits(nbits), .slot_free(slot_free),
    .move(move), .move_byte(move_byte), .drop(drop), .ovf(overflow));

  bp_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(move), .byte_in(move_byte),
    .rev_bits(rev_bits), .ready(out_ready), .slot_free(slot_free),
    .valid(out_valid), .data(out_data));

  assert_load_only_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    move |-> slot_free);
  assert_no_drop_on_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    width_chg |-> !drop);
endmodule

// File: tb/sim_bitpack_top.sv
module sim_bitpack_top;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        clear = 0;
  logic [2:0]  width_m1 = 3'd7;
  logic        rev_lines = 0, rev_bits = 0;
  logic        line_clk = 0;
  logic [15:0] lines = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1;
  logic        overflow;

  int checks = 0, errors = 0;
  logic [7:0] got [64];
  logic [7:0] expb [64];
  int ngot = 0, nexp = 0;
  logic mb [8];
  int mcnt = 0;
  int n_cur = 8;

  always #(CLK_P/2) clk = ~clk;

  bitpack_top u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .width_m1(width_m1),
    .rev_lines(rev_lines), .rev_bits(rev_bits), .line_clk(line_clk), .lines(lines),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .overflow(overflow));

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ngot < 64) begin
      got[ngot] = out_data;
      ngot++;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-serial reference
  task automatic model_push(input logic [15:0] v);
    for (int i = 0; i < n_cur; i++) begin
      mb[mcnt] = rev_lines ? v[15-i] : v[i];
      mcnt++;
      if (mcnt == 8) begin
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[rev_bits ? 7-j : j] = mb[j];
        expb[nexp] = b;
        nexp++;
        mcnt = 0;
      end
    end
  endtask

  task automatic send(input logic [15:0] v, input bit model = 1, input int hold = 4);
    lines = v;
    tick();
    line_clk = 1;
    tick(hold);
    line_clk = 0;
    tick(4);
    if (model) model_push(v);
  endtask

  task automatic begin_test(input int w, input bit rl, input bit rb);
    tick();
    width_m1 = 3'(w - 1);
    rev_lines = rl;
    rev_bits = rb;
    out_ready = 1;
    n_cur = w;
    tick();
    clear = 1;
    tick();
    clear = 0;
    tick(2);
    ngot = 0; nexp = 0; mcnt = 0;
  endtask

  task automatic check_stream(input string tag);
    tick(12);
    check({tag, " byte count"}, 32'(ngot), 32'(nexp));
    for (int i = 0; i < nexp && i < ngot; i++)
      check({tag, " byte"}, 32'(got[i]), 32'(expb[i]));
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", 32'(out_valid), 0);
    check("R1 overflow after reset", 32'(overflow), 0);
  endtask

  task automatic t_full_bytes();
    begin_test(8, 0, 0);
    send(16'h00A5); send(16'hFF3C); send(16'h120F);
    check_stream("R2 R3 width8");
  endtask

  task automatic t_nibble_literal();
    begin_test(4, 0, 0);
    send(16'hFFF3, 0); send(16'h00FA, 0);
    tick(10);
    check("R3 nibble byte count", 32'(ngot), 1);
    check("R3 nibble pair gives A3", 32'(got[0]), 32'h A3);
  endtask

  task automatic t_all_widths();
    int wl [7] = '{1, 2, 3, 4, 5, 6, 7};
    foreach (wl[k]) begin
      begin_test(wl[k], 0, 0);
      for (int s = 0; s < 8; s++) send(16'(s * 16'h9E37 + wl[k] * 16'h01F3));
      check_stream($sformatf("R3 R2 width%0d straddle", wl[k]));
    end
  endtask

  task automatic t_rev_lines();
    begin_test(4, 1, 0);
    send(16'hC000); send(16'h0005); send(16'h1234); send(16'h8001);
    check_stream("R4 line reversal");
    check("R4 first byte", 32'(got[0]), 32'h03);
  endtask

  task automatic t_rev_bits();
    begin_test(5, 0, 1);
    for (int s = 0; s < 8; s++) send(16'(s * 16'h0B17 + 16'h0031));
    check_stream("R5 byte mirror");
    begin_test(8, 0, 1);
    send(16'h0001, 0);
    tick(10);
    check("R5 mirrored 01 gives 80", 32'(got[0]), 32'h80);
  endtask

  task automatic t_single_edge();
    begin_test(8, 0, 0);
    send(16'h005A, 1, 30);
    check_stream("R6 long high one sample");
  endtask

  task automatic t_stall();
    begin_test(8, 0, 0);
    out_ready = 0;
    send(16'h0011, 1); send(16'h0022, 1); send(16'h0033, 1);
    send(16'h0044, 0);
    check("R7 valid held under stall", 32'(out_valid), 1);
    check("R7 data held under stall", 32'(out_data), 32'h11);
    tick(5);
    check("R7 data still held", 32'(out_data), 32'h11);
    check("R8 overflow set by drop", 32'(overflow), 1);
    out_ready = 1;
    check_stream("R8 held bytes delivered");
    check("R8 overflow sticky", 32'(overflow), 1);
  endtask

  task automatic t_width_flush();
    begin_test(3, 0, 0);
    send(16'h0007); send(16'h0005);
    width_m1 = 3'd7; n_cur = 8; mcnt = 0;
    tick(3);
    send(16'h0055);
    check_stream("R9 width change discards partial");
  endtask

  task automatic t_clear();
    tick();
    clear = 1; tick(); clear = 0; tick();
    check("R10 clear resets overflow", 32'(overflow), 0);
    begin_test(3, 0, 0);
    send(16'h0007); send(16'h0007);
    clear = 1; tick(); clear = 0; mcnt = 0; tick();
    send(16'h0001); send(16'h0002); send(16'h0003);
    check_stream("R10 clear discards partial");
    begin_test(8, 0, 0);
    out_ready = 0;
    send(16'h0099, 0);
    check("R10 pending before clear", 32'(out_valid), 1);
    clear = 1; tick(); clear = 0; tick();
    check("R10 clear withdraws byte", 32'(out_valid), 0);
    out_ready = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    t_reset();
    t_full_bytes();
    t_nibble_literal();
    t_all_widths();
    t_rev_lines();
    t_rev_bits();
    t_single_edge();
    t_stall();
    t_width_flush();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule